// File: doc/BRIEF.md
# Interrupt Arbiter with Non-Maskable Override

This block chooses one interrupt to present to the processor out of a set of maskable request lines and a single non-maskable request. Each maskable source carries a 5-bit priority level supplied by its own configuration logic. A smaller level value means higher priority, and the all-ones level switches the source off. The non-maskable request beats every maskable source. When it wins, the block presents a fixed level and a fixed number.

Along with the level and number, the block computes the address from which the processor fetches the handler pointer. The vector table grows downward from a programmable table base, so a higher interrupt number gives a lower address. A non-maskable request also sets a sticky flag that holds off DMA. Software can only clear this flag, and normally does so at the end of its handler. All outputs are registered and follow the inputs one clock later.

Top module: `irq_arbiter`

## Requirements
- R1: While `nmi_req` is high at a clock edge, the outputs after that edge show level 15 (5'b01111), number 15 (7'b0001111) and `irq_valid` 1, whatever the maskable requests are.
- R2: With no NMI, the enabled requesting source with the smallest level wins. Among sources at the same smallest level, the lowest index wins. Source i reports number 68+i.
- R3: A source whose level is 31 (5'b11111) is never selected. With no enabled request and no NMI, the outputs show `irq_valid` 0, level 31 and number 0.
- R4: `nmi_req` high at a clock edge makes `dma_halt` 1 after that edge.
- R5: `dma_halt` holds its value except in two cases. A write with `wr_addr`=1 and `wr_data` bit 0 equal to 0 clears it at the next edge. An NMI sets it. Writing 1 has no effect, and an NMI in the same cycle as a clearing write keeps the flag at 1.
- R6: `vec_addr` equals base + 0x3FC - 4*number for the presented number. The base used is the table base held before the edge that registers the outputs. The idle number 0 therefore gives base + 0x3FC.
- R7: The table base resets to 0x000FFC00, which puts the vector for number 68 at 0x000FFEEC. A write with `wr_addr`=0 loads `wr_data` into the base at the next edge.
- R8: After reset, the outputs are `irq_valid` 0, level 31, number 0, `dma_halt` 0 and `vec_addr` 0x000FFFFC.
- R9: The level, number, vector and valid outputs reflect the inputs sampled at the previous clock edge, which is one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 8 | Maskable request lines, one per source |
| src_lvl | input | 40 | Levels, 5 bits per source; source i is at bits [5i+4:5i] |
| nmi_req | input | 1 | Level-sensitive non-maskable request from the detector |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the table base, 1 selects the halt control |
| wr_data | input | 32 | Write data |
| irq_level | output | 5 | Winning level |
| irq_num | output | 7 | Winning interrupt number |
| vec_addr | output | 32 | Vector fetch address |
| irq_valid | output | 1 | Some source is selected |
| dma_halt | output | 1 | Sticky DMA halt flag |

## Verification
The properties assume that every input is stable at the sampling edge. They also assume that a rising `dma_halt` can only come from `nmi_req`, which means no path other than the NMI ever sets the flag. The bench changes inputs only on the falling edge. Its random stimulus mixes NMI pulses, clearing writes, writes of 1 and base reloads with arbitrary levels, including the disabled value and repeated levels that force ties. This lets the sticky-flag and priority properties meet their corner cases inside those assumptions.

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N_SRC     = 8,
  parameter int LVL_W     = 5,
  parameter int NUM_W     = 7,
  parameter int ADDR_W    = 32,
  parameter int FIRST_NUM = 68,
  parameter int NMI_LEVEL = 15,
  parameter int NMI_NUM   = 15,
  parameter int TABLE_TOP = 'h3FC,
  parameter logic [ADDR_W-1:0] BASE_RESET = 'h000FFC00
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_SRC-1:0]       req,
  input  logic [N_SRC*LVL_W-1:0] src_lvl,
  input  logic                   nmi_req,
  input  logic                   wr_en,
  input  logic                   wr_addr,
  input  logic [ADDR_W-1:0]      wr_data,
  output logic [LVL_W-1:0]       irq_level,
  output logic [NUM_W-1:0]       irq_num,
  output logic [ADDR_W-1:0]      vec_addr,
  output logic                   irq_valid,
  output logic                   dma_halt
);
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam logic [LVL_W-1:0] LVL_OFF = '1;

  logic              win_ok;
  logic [LVL_W-1:0]  win_lvl;
  logic [IDX_W-1:0]  win_idx;
  logic [LVL_W-1:0]  nxt_lvl;
  logic [NUM_W-1:0]  nxt_num;
  logic              nxt_valid;
  logic [ADDR_W-1:0] tbr;

  always_comb begin
    win_ok  = 1'b0;
    win_lvl = LVL_OFF;
    win_idx = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (req[i] && src_lvl[i*LVL_W +: LVL_W] != LVL_OFF &&
          (!win_ok || src_lvl[i*LVL_W +: LVL_W] < win_lvl)) begin
        win_ok  = 1'b1;
        win_lvl = src_lvl[i*LVL_W +: LVL_W];
        win_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    if (nmi_req) begin
      nxt_lvl   = LVL_W'(NMI_LEVEL);
      nxt_num   = NUM_W'(NMI_NUM);
      nxt_valid = 1'b1;
    end else if (win_ok) begin
      nxt_lvl   = win_lvl;
      nxt_num   = NUM_W'(FIRST_NUM) + NUM_W'(win_idx);
      nxt_valid = 1'b1;
    end else begin
      nxt_lvl   = LVL_OFF;
      nxt_num   = '0;
      nxt_valid = 1'b0;
    end
  end

  wire clr_halt = wr_en && wr_addr && !wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbr       <= BASE_RESET;
      dma_halt  <= 1'b0;
      irq_level <= LVL_OFF;
      irq_num   <= '0;
      irq_valid <= 1'b0;
      vec_addr  <= BASE_RESET + ADDR_W'(TABLE_TOP);
    end else begin
      if (wr_en && !wr_addr) tbr <= wr_data;
      if (nmi_req)           dma_halt <= 1'b1;
      else if (clr_halt)     dma_halt <= 1'b0;
      irq_level <= nxt_lvl;
      irq_num   <= nxt_num;
      irq_valid <= nxt_valid;
      vec_addr  <= tbr + ADDR_W'(TABLE_TOP) - (ADDR_W'(nxt_num) << 2);
    end
  end
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
  parameter int LVL_W = 5,
  parameter int NUM_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             nmi_req,
  input logic             wr_en,
  input logic             wr_addr,
  input logic             wr_bit0,
  input logic [LVL_W-1:0] irq_level,
  input logic [NUM_W-1:0] irq_num,
  input logic             irq_valid,
  input logic             dma_halt
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  assert_nmi_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |=> (irq_level == LVL_W'(15) && irq_num == NUM_W'(15) && irq_valid));

  assert_idle_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid |-> (irq_level == '1 && irq_num == '0));

  assert_nmi_sets_halt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |=> dma_halt);

  assert_halt_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_halt && !(wr_en && wr_addr && !wr_bit0)) |=> dma_halt);

  assert_halt_rise_from_nmi_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $rose(dma_halt)) |-> $past(nmi_req));
endmodule

bind irq_arbiter irq_arbiter_chk #(.LVL_W(LVL_W), .NUM_W(NUM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_bit0(wr_data[0]), .irq_level(irq_level),
  .irq_num(irq_num), .irq_valid(irq_valid), .dma_halt(dma_halt)
);

// File: tb/irq_arbiter_bench.sv
`timescale 1ns/1ps
module irq_arbiter_bench;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic [4:0]  lv [N];
  logic [N*5-1:0] src_lvl;
  logic        nmi_req = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [31:0] wr_data = '0;
  logic [4:0]  irq_level;
  logic [6:0]  irq_num;
  logic [31:0] vec_addr;
  logic        irq_valid;
  logic        dma_halt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] m_base;
  logic        m_halt;

  always #10 clk = ~clk;

  always_comb for (int i = 0; i < N; i++) src_lvl[i*5 +: 5] = lv[i];

  irq_arbiter u_irq_arbiter (
    .clk(clk), .rst_n(rst_n), .req(req), .src_lvl(src_lvl), .nmi_req(nmi_req),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .irq_level(irq_level),
    .irq_num(irq_num), .vec_addr(vec_addr), .irq_valid(irq_valid), .dma_halt(dma_halt)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Expected winner: scan from the top index down, keep any level <= best (R2, R3)
  function automatic void pick(output logic v, output logic [4:0] l, output logic [6:0] n);
    v = 1'b0; l = 5'd31; n = 7'd0;
    for (int i = N - 1; i >= 0; i--)
      if (req[i] && lv[i] != 5'd31 && (!v || lv[i] <= l)) begin
        v = 1'b1; l = lv[i]; n = 7'(68 + i);
      end
    if (nmi_req) begin v = 1'b1; l = 5'd15; n = 7'd15; end
  endfunction

  task automatic step();
    logic v; logic [4:0] l; logic [6:0] n; logic [31:0] a;
    pick(v, l, n);
    a = m_base + 32'h3FC - {23'd0, n, 2'b00};
    @(posedge clk); #1;
    if (nmi_req) m_halt = 1'b1;
    else if (wr_en && wr_addr && !wr_data[0]) m_halt = 1'b0;
    if (wr_en && !wr_addr) m_base = wr_data;
    chk(nmi_req ? "R1" : "R2", {27'd0, l}, {27'd0, irq_level});
    chk(v ? "R2_num" : "R3", {25'd0, irq_num}, {25'd0, n});
    chk("R3_valid", {31'd0, irq_valid}, {31'd0, v});
    chk("R6", vec_addr, a);
    chk("R5", {31'd0, dma_halt}, {31'd0, m_halt});
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < N; i++) lv[i] = 5'd31;
    m_base = 32'h000FFC00;
    m_halt = 1'b0;
    #45;
    // R8 reset state
    chk("R8", {irq_valid, irq_level, irq_num, dma_halt}, {1'b0, 5'd31, 7'd0, 1'b0});
    chk("R8_vec", vec_addr, 32'h000FFFFC);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    // R7 vector for number 68 at reset base; R9 latency
    req = 8'h01; lv[0] = 5'd3;
    step();
    chk("R7", vec_addr, 32'h000FFEEC);
    req = 8'h00;
    #1 chk("R9_hold", {25'd0, irq_num}, 32'd68);
    step();

    // R2 tie: sources 2 and 5 at level 4
    req = 8'h24; lv[2] = 5'd4; lv[5] = 5'd4;
    step();
    chk("R2_tie", {25'd0, irq_num}, 32'd70);

    // R3 disabled source even with level 31 requested alone
    req = 8'h80; lv[7] = 5'd31;
    step();

    // R1/R4 NMI with every source at level 0
    for (int i = 0; i < N; i++) lv[i] = 5'd0;
    req = '1; nmi_req = 1'b1;
    step();
    nmi_req = 1'b0;
    // R5 writing 1 keeps halt
    wr_en = 1'b1; wr_addr = 1'b1; wr_data = 32'h1;
    step();
    chk("R5_w1", {31'd0, dma_halt}, 32'd1);
    // R5 clear together with NMI keeps halt
    wr_en = 1'b1; wr_addr = 1'b1; wr_data = 32'h0; nmi_req = 1'b1;
    step();
    chk("R5_race", {31'd0, dma_halt}, 32'd1);
    nmi_req = 1'b0;
    wr_en = 1'b1; wr_addr = 1'b1; wr_data = 32'h0;
    step();
    chk("R5_clr", {31'd0, dma_halt}, 32'd0);

    // R7 base write
    wr_en = 1'b1; wr_addr = 1'b0; wr_data = 32'h2000_0000;
    step();
    step();

    for (int k = 0; k < 400; k++) begin
      req = 8'($urandom);
      for (int i = 0; i < N; i++)
        lv[i] = ($urandom_range(0, 5) == 0) ? 5'd31 : 5'($urandom_range(0, 7));
      nmi_req = ($urandom_range(0, 9) == 0);
      if ($urandom_range(0, 5) == 0) begin
        wr_en = 1'b1; wr_addr = 1'b1; wr_data = 32'($urandom_range(0, 1));
      end else if ($urandom_range(0, 30) == 0) begin
        wr_en = 1'b1; wr_addr = 1'b0; wr_data = $urandom;
      end
      step();
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule